// File: doc/BRIEF.md
# Receive Link Synchronization Monitor

This block sits behind a pair of 8b/10b decoders on the receive side of a serial link. On every word clock it takes the classification the decoders give to one 20-bit received word. The word is one of idle, carrier extend, normal data, error propagation, or an invalid code. The block also takes the decoded 16-bit payload and a loss-of-signal flag from the analog detector. It runs the acquisition, synchronized and checking states of the link. It tells the comma aligner when the link is established and when synchronization has been lost, so that alignment can be frozen or re-armed.

The block also produces the receive status pair (data valid, error) and the receive data bus. The status pair encodes the kind of word presented. Fixed code patterns are substituted on the data bus where the word type requires them. When the loss-of-signal flag is raised, every status and data output is driven high. All outputs are registered and show the effect of a word one clock after it is presented.

Top module: `rx_link_sync`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released with no word applied, the state output reads acquisition (code 0) and rx_dv_o, rx_er_o, rx_data_o, link_up_o and realign_o are all 0.
- R2: In acquisition, three consecutive words that are idle (class code 0) or carrier extend (class code 1), in any mix, move the state to synchronized (code 1). An invalid word restarts this count from zero.
- R3: In acquisition, a single normal data word (class code 2) or error propagation word (class code 3) moves the state to synchronized on that word.
- R4: In synchronized, an invalid word (class code 4, and the unused codes 5 to 7) moves the state to checking (code 2). Any other class leaves the state in synchronized.
- R5: In checking, four consecutive non-invalid words return the state to synchronized. Any invalid word in checking restarts this consecutive count.
- R6: In checking, the third invalid word since entering checking moves the state to acquisition, whether or not the invalid words are consecutive. The invalid count starts at zero on each entry to checking, so the invalid word that caused the entry is not counted.
- R7: A normal data word gives rx_dv_o=1, rx_er_o=0, and the payload unchanged on rx_data_o.
- R8: A carrier extend word gives rx_dv_o=0, rx_er_o=1 and data 0xF7F7. An idle word gives rx_dv_o=0, rx_er_o=0, data bits [7:0]=0xBC, and bits [15:8] taken from the payload (0xC5 or 0x50).
- R9: An error propagation word gives rx_dv_o=1, rx_er_o=1 and data 0xFEFE. An invalid word gives rx_dv_o=1, rx_er_o=1 and the payload unchanged.
- R10: While loss of signal is raised, rx_dv_o, rx_er_o and all data bits are 1, whatever word class is applied. The state is sent to acquisition and all counts are cleared.
- R11: link_up_o is 1 exactly when the state is synchronized or checking. realign_o is a one-clock pulse on each entry into acquisition from another state.
- R12: Every output reflects the word applied at the previous rising clock edge, with one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| los_i | input | 1 | Loss-of-signal flag from the signal detector |
| word_class_i | input | 3 | Decoder classification: 0 idle, 1 carrier extend, 2 data, 3 error propagation, 4 to 7 invalid |
| word_data_i | input | 16 | Decoded payload, low byte first on the wire |
| rx_dv_o | output | 1 | Receive data-valid status |
| rx_er_o | output | 1 | Receive error status |
| rx_data_o | output | 16 | Receive data bus |
| sync_state_o | output | 2 | Link state: 0 acquisition, 1 synchronized, 2 checking |
| link_up_o | output | 1 | Link established, comma alignment may be frozen |
| realign_o | output | 1 | One-clock pulse: synchronization lost, re-arm comma alignment |

## Verification
A wrong state or count inside this block appears at sync_state_o and link_up_o one clock after the word that exposes it. Examples are a counter that is not cleared, or an exit taken one word early or late. The fault can also show up later, because a stale idle or invalid count shifts the word on which a later transition lands. Errors in the status encoding show on rx_dv_o, rx_er_o and rx_data_o on the clock after the offending word. The sweep over every six-word class sequence from reset reaches each exit of each state, including four good words in checking and three scattered invalid words in checking. Directed runs cover loss of signal, the unused class codes and long interleavings in checking.

// File: rtl/rxls_pkg.sv
package rxls_pkg;

    typedef enum logic [2:0] {
        WC_IDLE  = 3'd0,
        WC_CEXT  = 3'd1,
        WC_DATA  = 3'd2,
        WC_EPROP = 3'd3,
        WC_BAD   = 3'd4
    } wclass_e;

    typedef enum logic [1:0] {
        ST_ACQ   = 2'd0,
        ST_SYNC  = 2'd1,
        ST_CHECK = 2'd2
    } sync_st_e;

    localparam logic [7:0] IDLE_K_BYTE  = 8'hBC;
    localparam logic [7:0] CEXT_BYTE    = 8'hF7;
    localparam logic [7:0] EPROP_BYTE   = 8'hFE;

    function automatic logic cls_invalid(input logic [2:0] c);
        return c > 3'd3;
    endfunction

endpackage

// File: rtl/rxls_seq.sv
module rxls_seq
    import rxls_pkg::*;
#(
    parameter int ACQ_IDLES  = 3,
    parameter int CHECK_GOOD = 4,
    parameter int CHECK_BAD  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       los_i,
    input  logic [2:0] cls_i,
    output sync_st_e   state_o,
    output logic       realign_o
);

    localparam int AW = $clog2(ACQ_IDLES + 1);
    localparam int GW = $clog2(CHECK_GOOD + 1);
    localparam int BW = $clog2(CHECK_BAD + 1);
    localparam logic [AW-1:0] IDL_LAST  = AW'(ACQ_IDLES - 1);
    localparam logic [GW-1:0] GOOD_LAST = GW'(CHECK_GOOD - 1);
    localparam logic [BW-1:0] BAD_LAST  = BW'(CHECK_BAD - 1);

    typedef struct packed {
        sync_st_e        st;
        logic [AW-1:0]   idl;
        logic [GW-1:0]   good;
        logic [BW-1:0]   bad;
        logic            realign;
    } seq_t;

    seq_t seq_d, seq_q;
    logic inv;

    assign inv = cls_invalid(cls_i);

    always_comb begin
        seq_d         = seq_q;
        seq_d.realign = 1'b0;
        if (los_i) begin
            seq_d.st   = ST_ACQ;
            seq_d.idl  = '0;
            seq_d.good = '0;
            seq_d.bad  = '0;
        end else begin
            unique case (seq_q.st)
                ST_ACQ: begin
                    if (inv) begin
                        seq_d.idl = '0;
                    end else if (cls_i == WC_IDLE || cls_i == WC_CEXT) begin
                        if (seq_q.idl == IDL_LAST) begin
                            seq_d.st  = ST_SYNC;
                            seq_d.idl = '0;
                        end else begin
                            seq_d.idl = seq_q.idl + AW'(1);
                        end
                    end else begin
                        seq_d.st  = ST_SYNC;
                        seq_d.idl = '0;
                    end
                end
                ST_SYNC: begin
                    if (inv) begin
                        seq_d.st   = ST_CHECK;
                        seq_d.good = '0;
                        seq_d.bad  = '0;
                    end
                end
                ST_CHECK: begin
                    if (inv) begin
                        seq_d.good = '0;
                        if (seq_q.bad == BAD_LAST) begin
                            seq_d.st  = ST_ACQ;
                            seq_d.bad = '0;
                        end else begin
                            seq_d.bad = seq_q.bad + BW'(1);
                        end
                    end else begin
                        if (seq_q.good == GOOD_LAST) begin
                            seq_d.st   = ST_SYNC;
                            seq_d.good = '0;
                        end else begin
                            seq_d.good = seq_q.good + GW'(1);
                        end
                    end
                end
                default: begin
                    seq_d.st = ST_ACQ;
                end
            endcase
        end
        seq_d.realign = (seq_d.st == ST_ACQ) && (seq_q.st != ST_ACQ);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_ACQ, idl: '0, good: '0, bad: '0, realign: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o   = seq_q.st;
    assign realign_o = seq_q.realign;

endmodule

// File: rtl/rxls_status.sv
module rxls_status
    import rxls_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              los_i,
    input  logic [2:0]        cls_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              dv_o,
    output logic              er_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int NB = DATA_W / 8;

    typedef struct packed {
        logic              dv;
        logic              er;
        logic [DATA_W-1:0] data;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (los_i) begin
            st_d.dv   = 1'b1;
            st_d.er   = 1'b1;
            st_d.data = '1;
        end else begin
            case (cls_i)
                WC_IDLE: begin
                    st_d.data      = data_i;
                    st_d.data[7:0] = IDLE_K_BYTE;
                end
                WC_CEXT: begin
                    st_d.er   = 1'b1;
                    st_d.data = {NB{CEXT_BYTE}};
                end
                WC_DATA: begin
                    st_d.dv   = 1'b1;
                    st_d.data = data_i;
                end
                WC_EPROP: begin
                    st_d.dv   = 1'b1;
                    st_d.er   = 1'b1;
                    st_d.data = {NB{EPROP_BYTE}};
                end
                default: begin
                    st_d.dv   = 1'b1;
                    st_d.er   = 1'b1;
                    st_d.data = data_i;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dv_o   = st_q.dv;
    assign er_o   = st_q.er;
    assign data_o = st_q.data;

endmodule

// File: rtl/rx_link_sync.sv
module rx_link_sync
    import rxls_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int ACQ_IDLES  = 3,
    parameter int CHECK_GOOD = 4,
    parameter int CHECK_BAD  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              los_i,
    input  logic [2:0]        word_class_i,
    input  logic [DATA_W-1:0] word_data_i,
    output logic              rx_dv_o,
    output logic              rx_er_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic [1:0]        sync_state_o,
    output logic              link_up_o,
    output logic              realign_o
);

    sync_st_e st;

    rxls_seq #(
        .ACQ_IDLES (ACQ_IDLES),
        .CHECK_GOOD(CHECK_GOOD),
        .CHECK_BAD (CHECK_BAD)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .los_i    (los_i),
        .cls_i    (word_class_i),
        .state_o  (st),
        .realign_o(realign_o)
    );

    rxls_status #(
        .DATA_W(DATA_W)
    ) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .los_i (los_i),
        .cls_i (word_class_i),
        .data_i(word_data_i),
        .dv_o  (rx_dv_o),
        .er_o  (rx_er_o),
        .data_o(rx_data_o)
    );

    assign sync_state_o = st;
    assign link_up_o    = (st != ST_ACQ);

endmodule

// File: rtl/rxls_chk.sv
module rxls_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              los_i,
    input logic [2:0]        word_class_i,
    input logic [DATA_W-1:0] word_data_i,
    input logic              rx_dv_o,
    input logic              rx_er_o,
    input logic [DATA_W-1:0] rx_data_o,
    input logic [1:0]        sync_state_o,
    input logic              link_up_o,
    input logic              realign_o
);

    localparam int NB = DATA_W / 8;

    assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sync_state_o != 2'd3);

    assert_acq_fast_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!los_i && sync_state_o == 2'd0 && (word_class_i == 3'd2 || word_class_i == 3'd3))
        |=> sync_state_o == 2'd1);

    assert_sync_to_check_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!los_i && sync_state_o == 2'd1 && word_class_i > 3'd3) |=> sync_state_o == 2'd2);

    assert_sync_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!los_i && sync_state_o == 2'd1 && word_class_i <= 3'd3) |=> sync_state_o == 2'd1);

    assert_check_not_acq_on_good_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!los_i && sync_state_o == 2'd2 && word_class_i <= 3'd3) |=> sync_state_o != 2'd0);

    assert_data_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!los_i && word_class_i == 3'd2)
        |=> (rx_dv_o && !rx_er_o && rx_data_o == $past(word_data_i)));

    assert_cext_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!los_i && word_class_i == 3'd1)
        |=> (!rx_dv_o && rx_er_o && rx_data_o == {NB{8'hF7}}));

    assert_idle_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!los_i && word_class_i == 3'd0)
        |=> (!rx_dv_o && !rx_er_o && rx_data_o[7:0] == 8'hBC));

    assert_eprop_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!los_i && word_class_i == 3'd3)
        |=> (rx_dv_o && rx_er_o && rx_data_o == {NB{8'hFE}}));

    assert_los_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        los_i |=> (rx_dv_o && rx_er_o && (&rx_data_o)));

    assert_los_acq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        los_i |=> (sync_state_o == 2'd0 && !link_up_o));

    assert_realign_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_state_o != 2'd0) |=> (realign_o == (sync_state_o == 2'd0)));

    assert_realign_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
        realign_o |=> !realign_o);

endmodule

bind rx_link_sync rxls_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .los_i       (los_i),
    .word_class_i(word_class_i),
    .word_data_i (word_data_i),
    .rx_dv_o     (rx_dv_o),
    .rx_er_o     (rx_er_o),
    .rx_data_o   (rx_data_o),
    .sync_state_o(sync_state_o),
    .link_up_o   (link_up_o),
    .realign_o   (realign_o)
);

// File: tb/rx_link_sync_tb.sv
module rx_link_sync_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        los_i = 1'b0;
    logic [2:0]  word_class_i = 3'd0;
    logic [15:0] word_data_i = 16'h0;
    logic        rx_dv_o, rx_er_o, link_up_o, realign_o;
    logic [15:0] rx_data_o;
    logic [1:0]  sync_state_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    int m_st = 0, m_idl = 0, m_good = 0, m_bad = 0;

    always #5 clk = ~clk;

    rx_link_sync u_dut (
        .clk(clk), .rst_n(rst_n), .los_i(los_i),
        .word_class_i(word_class_i), .word_data_i(word_data_i),
        .rx_dv_o(rx_dv_o), .rx_er_o(rx_er_o), .rx_data_o(rx_data_o),
        .sync_state_o(sync_state_o), .link_up_o(link_up_o), .realign_o(realign_o)
    );

    task automatic cmp(input string req, input string what, input int act, input int exp);
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (time %0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        los_i = 1'b0;
        word_class_i = 3'd0;
        word_data_i = 16'h0;
        @(negedge clk);
        m_st = 0; m_idl = 0; m_good = 0; m_bad = 0;
        n_vec++;
        cmp("R1", "state in reset", int'(sync_state_o), 0);
        cmp("R1", "dv/er in reset", int'({rx_dv_o, rx_er_o}), 0);
        cmp("R1", "data in reset", int'(rx_data_o), 0);
        cmp("R1", "link/realign in reset", int'({link_up_o, realign_o}), 0);
        rst_n = 1'b1;
    endtask

    // Drives one word at a negedge, waits through the rising edge, checks at the next negedge.
    task automatic apply(input logic [2:0] c, input logic l, input logic [15:0] d, input string req);
        int old_st, ns, edv, eer, edata, erl;
        bit inv;
        word_class_i = c;
        los_i = l;
        word_data_i = d;
        @(negedge clk);
        inv = (c > 3'd3);
        old_st = m_st;
        ns = m_st;
        if (l) begin
            ns = 0; m_idl = 0; m_good = 0; m_bad = 0;
        end else begin
            case (m_st)
                0: begin
                    if (inv) m_idl = 0;
                    else if (c == 3'd0 || c == 3'd1) begin
                        if (m_idl == 2) begin ns = 1; m_idl = 0; end
                        else m_idl++;
                    end else begin
                        ns = 1; m_idl = 0;
                    end
                end
                1: if (inv) begin ns = 2; m_good = 0; m_bad = 0; end
                default: begin
                    if (inv) begin
                        m_good = 0;
                        if (m_bad == 2) begin ns = 0; m_bad = 0; end
                        else m_bad++;
                    end else begin
                        if (m_good == 3) begin ns = 1; m_good = 0; end
                        else m_good++;
                    end
                end
            endcase
        end
        m_st = ns;
        if (l) begin edv = 1; eer = 1; edata = 16'hFFFF; end
        else begin
            case (c)
                3'd0: begin edv = 0; eer = 0; edata = {d[15:8], 8'hBC}; end
                3'd1: begin edv = 0; eer = 1; edata = 16'hF7F7; end
                3'd2: begin edv = 1; eer = 0; edata = d; end
                3'd3: begin edv = 1; eer = 1; edata = 16'hFEFE; end
                default: begin edv = 1; eer = 1; edata = d; end
            endcase
        end
        erl = (ns == 0 && old_st != 0) ? 1 : 0;
        n_vec++;
        cmp(req, "state", int'(sync_state_o), ns);
        cmp("R12", "rx_dv_o", int'(rx_dv_o), edv);
        cmp("R12", "rx_er_o", int'(rx_er_o), eer);
        cmp("R12", "rx_data_o", int'(rx_data_o), edata);
        cmp("R11", "link_up_o", int'(link_up_o), (ns != 0) ? 1 : 0);
        cmp("R11", "realign_o", int'(realign_o), erl);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R12 watchdog: finished 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: one clock after release with idle applied, still in acquisition.
        apply(3'd0, 1'b0, 16'hC500, "R1");

        // R2: mix of idle and carrier extend, interrupted by an invalid word.
        do_reset();
        apply(3'd0, 1'b0, 16'hC511, "R2");
        apply(3'd1, 1'b0, 16'h1234, "R2");
        apply(3'd4, 1'b0, 16'hDEAD, "R2");
        apply(3'd1, 1'b0, 16'h0000, "R2");
        apply(3'd0, 1'b0, 16'h5022, "R8");
        apply(3'd0, 1'b0, 16'hC533, "R2");

        // R4: unused class codes count as invalid in synchronized.
        apply(3'd6, 1'b0, 16'hBEEF, "R4");
        // R5: three good, invalid restarts, then four good back to synchronized.
        apply(3'd2, 1'b0, 16'h0101, "R5");
        apply(3'd3, 1'b0, 16'h0202, "R5");
        apply(3'd0, 1'b0, 16'h5003, "R5");
        apply(3'd7, 1'b0, 16'h0404, "R5");
        apply(3'd2, 1'b0, 16'h0505, "R5");
        apply(3'd1, 1'b0, 16'h0606, "R5");
        apply(3'd2, 1'b0, 16'h0707, "R5");
        apply(3'd2, 1'b0, 16'h0808, "R5");

        // R6: scattered invalid words in checking return to acquisition.
        apply(3'd5, 1'b0, 16'h1111, "R6");
        apply(3'd4, 1'b0, 16'h2222, "R6");
        apply(3'd2, 1'b0, 16'h3333, "R6");
        apply(3'd2, 1'b0, 16'h4444, "R6");
        apply(3'd4, 1'b0, 16'h5555, "R6");
        apply(3'd0, 1'b0, 16'hC566, "R6");
        apply(3'd4, 1'b0, 16'h7777, "R6");

        // R10: loss of signal from synchronized, then while in acquisition.
        apply(3'd2, 1'b0, 16'hABCD, "R3");
        apply(3'd2, 1'b1, 16'h0000, "R10");
        apply(3'd0, 1'b1, 16'hC500, "R10");
        apply(3'd0, 1'b0, 16'hC500, "R10");
        apply(3'd0, 1'b0, 16'h5000, "R10");
        apply(3'd3, 1'b1, 16'h1357, "R10");
        apply(3'd3, 1'b0, 16'h1357, "R3");

        // Exhaustive sweep: every six-word class sequence over codes 0..4 from reset.
        for (int s = 0; s < 15625; s++) begin
            int v;
            do_reset();
            v = s;
            for (int k = 0; k < 6; k++) begin
                logic [2:0]  c;
                logic [15:0] d;
                c = 3'(v % 5);
                v = v / 5;
                d = 16'(s * 7 + k * 16'h1111) ^ 16'h5A00;
                if (c == 3'd0) d[15:8] = (k % 2 == 1) ? 8'hC5 : 8'h50;
                apply(c, 1'b0, d, "R2");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule